// File: doc/BRIEF.md
# Transmit Suppression Attenuator

This block sits in the transmit path of a hands-free voice channel running at an 8 kHz word rate. For every transmit sample it decides whether extra attenuation should be inserted. That decision is used to quiet residual echo when the local talker is silent. The decision takes two per-frame speech flags from external detectors: one for near-end speech and one for receive-path (far-end) speech. It also takes a disable bit, a mode bit and a 2-bit attenuation setting.

The applied attenuation does not jump. It walks toward its target one step per accepted sample, and each step is one twelfth of a halving (about 0.5 dB). Engaging and releasing follow the same rate, so there are no audible clicks. The block scales each sample by the gain of the current level, then rounds and saturates the result. It presents the result one clock later, together with a registered flag that shows whether suppression is engaged for that sample.

Top module: `tx_supp_atten`

## Requirements
- R1: After reset, out_valid, engaged and out_sample are 0, and the attenuation level is 0 (unity gain).
- R2: While supp_off is 1, suppression never engages: the target level is 0 and engaged reads 0.
- R3: With far_mode at 0, suppression engages on a sample whenever near_speech is 0, regardless of far_speech.
- R4: With far_mode at 1, suppression engages only when far_speech is 1 and near_speech is 0.
- R5: A sample with near_speech at 1 never engages suppression, and its target level is 0.
- R6: When engaged, the target level in steps is 12 × (atten_sel + 1): 12, 24, 36 or 48 steps for atten_sel 0, 1, 2, 3 (6, 12, 18, 24 dB). When not engaged, the target is 0.
- R7: Each sample with in_valid at 1 moves the level exactly one step toward the target, or leaves it unchanged when it equals the target. The level is unchanged on cycles without in_valid.
- R8: The gain for level L is the Q15 value G = round(32768 · 2^(-(L mod 12)/12)) shifted right by L div 12. The output is floor((x·G + 16384) / 32768), saturated to the 16-bit signed range. L is the level after this sample's step.
- R9: out_valid, out_sample and engaged are registered. They reflect the sample accepted on the previous clock edge, and out_valid is 0 one cycle after a cycle without in_valid.
- R10: At level 0 the output sample equals the input sample exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transmit sample strobe, one per frame |
| in_sample | input | 16 | Signed transmit sample |
| near_speech | input | 1 | Near-end speech detected for this frame |
| far_speech | input | 1 | Receive-path speech detected for this frame |
| supp_off | input | 1 | 1 disables suppression |
| far_mode | input | 1 | 0: engage when near end is silent; 1: also require far-end speech |
| atten_sel | input | 2 | Attenuation depth select |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Attenuated signed sample |
| engaged | output | 1 | Suppression engaged for the sample on out_sample |

## Verification
The level step and the engage decision both act on the same sample. A sample that flips the decision is therefore already scaled by a level stepped in the new direction, and the engaged flag changes on that very output. The bench provokes this by toggling near_speech, far_speech and the mode in the middle of a ramp, with both random and directed runs. It judges each output against a level model that steps once per accepted sample and computes the gain from real-valued powers of two.

// File: rtl/tx_supp_atten.sv
module tx_supp_atten #(
  parameter int W = 16,
  parameter int STEPS_PER_HALF = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  input  logic         near_speech,
  input  logic         far_speech,
  input  logic         supp_off,
  input  logic         far_mode,
  input  logic [1:0]   atten_sel,
  output logic         out_valid,
  output logic [W-1:0] out_sample,
  output logic         engaged
);
  localparam int LMAX = 4 * STEPS_PER_HALF;
  localparam int LW   = $clog2(LMAX + 1);
  localparam int GW   = 17;
  localparam int PW   = W + GW;
  localparam logic signed [PW-1:0] HI = PW'(2 ** (W - 1) - 1);
  localparam logic signed [PW-1:0] LO = -HI - 1;

  logic          want;
  logic [LW-1:0] lvl, lvl_nx, tgt;
  logic [3:0]    frac;
  logic [2:0]    oct;
  logic [15:0]   mant;
  logic [GW-1:0] gain;
  logic signed [PW-1:0] prod, rnd, sh;
  logic [W-1:0]  sat;

  assign want   = !supp_off && !near_speech && (!far_mode || far_speech);
  assign tgt    = want ? LW'(STEPS_PER_HALF * (int'(atten_sel) + 1)) : '0;
  assign lvl_nx = (lvl < tgt) ? lvl + 1'b1 : (lvl > tgt) ? lvl - 1'b1 : lvl;

  assign frac = 4'(lvl_nx % LW'(12));
  assign oct  = 3'(lvl_nx / LW'(12));

  always_comb begin
    case (frac)
      4'd0:    mant = 16'd32768;
      4'd1:    mant = 16'd30929;
      4'd2:    mant = 16'd29193;
      4'd3:    mant = 16'd27554;
      4'd4:    mant = 16'd26008;
      4'd5:    mant = 16'd24548;
      4'd6:    mant = 16'd23170;
      4'd7:    mant = 16'd21870;
      4'd8:    mant = 16'd20643;
      4'd9:    mant = 16'd19484;
      4'd10:   mant = 16'd18390;
      default: mant = 16'd17358;
    endcase
  end

  assign gain = {1'b0, mant} >> oct;
  assign prod = $signed({{GW{in_sample[W-1]}}, in_sample}) * $signed({{W{1'b0}}, gain});
  assign rnd  = prod + PW'(16384);
  assign sh   = rnd >>> 15;
  assign sat  = (sh > HI) ? W'(HI) : (sh < LO) ? W'(LO) : sh[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      engaged    <= 1'b0;
      lvl        <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lvl        <= lvl_nx;
        out_sample <= sat;
        engaged    <= want;
      end
    end
  end
endmodule

// File: rtl/tx_supp_atten_chk.sv
module tx_supp_atten_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_sample,
  input logic        near_speech,
  input logic        supp_off,
  input logic        out_valid,
  input logic [15:0] out_sample,
  input logic        engaged,
  input logic [5:0]  lvl
);
  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n) lvl <= 6'd48);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R2
  off_disengage_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid && supp_off |=> !engaged);
  // R5
  near_disengage_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid && near_speech |=> !engaged);
  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(lvl));
  // R7
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (lvl == $past(lvl)) || (lvl == $past(lvl) + 6'd1) || (lvl + 6'd1 == $past(lvl)));
  // R10
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (lvl != 6'd0) || (out_sample == $past(in_sample)));
endmodule

bind tx_supp_atten tx_supp_atten_chk u_chk (.*);

// File: tb/test_tx_supp_atten.sv
`timescale 1ns/1ps
module test_tx_supp_atten;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, near = 0, far = 0, off = 0, mode = 0;
  logic [15:0] x = 0;
  logic [1:0] sel = 0;
  logic out_valid, engaged;
  logic [15:0] y;
  int checks = 0, fails = 0, lvl_m = 0;

  always #2.5 clk = ~clk;

  tx_supp_atten i_tx_supp_atten (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(x),
    .near_speech(near), .far_speech(far), .supp_off(off), .far_mode(mode),
    .atten_sel(sel), .out_valid(out_valid), .out_sample(y), .engaged(engaged));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit want_of(bit n, bit f, bit o, bit m);
    return !o && !n && (!m || f);
  endfunction

  function automatic int gain_of(int l);
    real r;
    int g;
    r = real'(l % 12) / 12.0;
    g = $rtoi(32768.0 * (2.0 ** (-r)) + 0.5);
    return g >> (l / 12);
  endfunction

  function automatic longint out_of(logic signed [15:0] s, int l);
    longint p, q;
    p = longint'(s) * longint'(gain_of(l));
    q = (p + 16384) >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic send(input logic [15:0] s, input bit n, input bit f, input bit o,
                      input bit m, input logic [1:0] a, input string req);
    bit w;
    int t;
    longint e;
    x = s; near = n; far = f; off = o; mode = m; sel = a; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    w = want_of(n, f, o, m);
    t = w ? 12 * (int'(a) + 1) : 0;
    if (lvl_m < t) lvl_m++;
    else if (lvl_m > t) lvl_m--;
    e = out_of($signed(s), lvl_m);
    check(out_valid === 1'b1, "R9", longint'(out_valid), 1);
    check(engaged === w, req, longint'(engaged), longint'(w));
    check($signed(y) == e, req, longint'($signed(y)), e);
  endtask

  task automatic idle();
    in_valid = 0;
    @(negedge clk);
    check(out_valid === 1'b0, "R9", longint'(out_valid), 0);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    bit n, f, o, m;
    logic [1:0] a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    check(engaged === 1'b0, "R1", longint'(engaged), 0);
    check(y === 16'd0, "R1", longint'(y), 0);
    // R1 R10: level starts at unity
    send(16'h7abc, 1, 0, 0, 0, 2'd3, "R10");
    // R2: disabled, silent near end
    send(16'd12345, 0, 1, 1, 0, 2'd3, "R2");
    send(16'h8000, 0, 1, 1, 1, 2'd3, "R2");
    // R3 R6 R8: full ramp to deepest setting with extreme inputs
    for (int i = 0; i < 52; i++)
      send((i % 2) ? 16'h8000 : 16'h7fff, 0, i % 3 == 0, 0, 0, 2'd3, "R3");
    // R6: settle to shallower target from above
    for (int i = 0; i < 40; i++) send(16'd20000, 0, 0, 0, 0, 2'd0, "R6");
    // R7: gaps hold the level
    idle(); idle();
    send(16'd30000, 0, 0, 0, 0, 2'd0, "R7");
    // R5: near end releases, same rate
    for (int i = 0; i < 14; i++) send(-16'sd25000, 1, 1, 0, i % 2 == 1, 2'd2, "R5");
    // R4: far-end gated mode
    for (int i = 0; i < 6; i++) send(16'd1000, 0, 0, 0, 1, 2'd1, "R4");
    for (int i = 0; i < 20; i++) send(16'd1000, 0, 1, 0, 1, 2'd1, "R4");
    send(16'd1000, 1, 1, 0, 1, 2'd1, "R5");
    for (int i = 0; i < 30; i++) send(16'd1000, 0, 0, 0, 1, 2'd1, "R4");
    // R8: random mix, decision flips mid-ramp
    n = 0; f = 0; o = 0; m = 0; a = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        n = ($urandom_range(0, 2) == 0);
        f = $urandom_range(0, 1) == 1;
        o = ($urandom_range(0, 9) == 0);
        m = $urandom_range(0, 1) == 1;
        a = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 7) == 0) idle();
      send(16'($urandom), n, f, o, m, a, "R8");
    end
    finish_up();
  end
endmodule